// File: doc/BRIEF.md
# Selectable-input serial delay line

A chain of serial-in, serial-out shift registers, each 64 bits deep, that delays a bit stream by a whole number of 64-bit segments. A 2:1 select in front of the first stage picks the bit loaded on each rising edge. With `sel_i` LOW the new bit comes from `din_i`. With `sel_i` HIGH it comes from a holding flip-flop that keeps the final output, so the chain recirculates its own contents. Only the far end of the chain is visible, on a true output and a complemented output.

The chain is built from `NUM_DEV` identical segments. The system clock drives the segment nearest the output. Each segment passes its clock on, unchanged, through a clock output to the segment before it, and the head segment's clock output leaves the block as `clk_o`. The holding flip-flop runs on the system clock. It captures the last stage before the head segment reads it, so a recirculated bit is neither lost nor repeated. Shift stages have no reset. Their contents are unknown until enough known bits have been shifted in. The active-low reset clears only the holding flip-flop.

Top module: `sdly_cascade`

## Requirements
- R1: `dout_n_o` is always the logical inverse of `dout_o`, and inside every segment the complemented tap is the inverse of that segment's last stage.
- R2: With `sel_i` LOW at a rising edge of `clk_i`, the value on `din_i` enters the first stage. With the defaults, it first shows on `dout_o` after the 128th rising edge counted from and including the loading edge (64 × `NUM_DEV`).
- R3: With `sel_i` HIGH at a rising edge, `din_i` has no effect. The first stage loads the holding flip-flop, which captures the last stage on every rising edge. Steady recirculation therefore repeats the output sequence with a period of 64 × `NUM_DEV` + 1 edges.
- R4: `sel_i` is sampled on the same rising edge as the data, with no latching. Changing it from one edge to the next switches the source at exactly that edge.
- R5: `clk_o` follows `clk_i` combinationally, HIGH while `clk_i` is HIGH and LOW while it is LOW.
- R6: Outputs change only at rising edges of `clk_i`. Changes on `din_i` or `sel_i` between rising edges leave `dout_o` and `dout_n_o` unchanged.
- R7: Asserting `rst_ni` (LOW) clears the holding flip-flop to 0 and leaves every shift stage unchanged. The bit stream continues across a reset pulse, and the first recirculated bit after it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, rising-edge active; drives the output-end segment and the holding flip-flop |
| rst_ni | input | 1 | Active-low asynchronous clear of the holding flip-flop only |
| sel_i | input | 1 | Source select for the first stage: 0 = `din_i`, 1 = recirculated bit |
| din_i | input | 1 | Serial data input |
| dout_o | output | 1 | Last stage of the chain |
| dout_n_o | output | 1 | Inverse of `dout_o` |
| clk_o | output | 1 | Clock passed through from the head segment |

## Verification
The complement checks are guarded so that they start only once a stage holds a known value. The checks on loading and on the links between segments compare a stage against the previous cycle's source. Both rely on the absence of any data reset, so they stay valid across reset pulses, and the bench pulses reset only between clock edges. The bench changes `din_i` and `sel_i` during the clock's high phase and sets their real values during the low phase, so every edge samples settled inputs. The reference model is compared only after it has filled with known bits.

// File: rtl/sdly_pkg.sv
package sdly_pkg;
  localparam int unsigned SEG_STAGES = 64;

  typedef enum logic {
    SRC_DIN  = 1'b0,
    SRC_HOLD = 1'b1
  } src_sel_e;
endpackage

// File: rtl/sdly_in_mux.sv
module sdly_in_mux
  import sdly_pkg::*;
(
  input  logic sel_i,
  input  logic a_i,
  input  logic b_i,
  output logic y_o
);
  always_comb begin
    unique case (src_sel_e'(sel_i))
      SRC_DIN:  y_o = a_i;
      SRC_HOLD: y_o = b_i;
      default:  y_o = a_i;
    endcase
  end
endmodule

// File: rtl/sdly_shift_line.sv
module sdly_shift_line #(
  parameter int unsigned STAGES = 64
) (
  input  logic clk_i,
  input  logic d_i,
  output logic first_o,
  output logic last_o
);
  localparam int unsigned LastIdx = STAGES - 1;

  logic [LastIdx:0] q;

  // no reset on data stages by intent
  always_ff @(posedge clk_i) begin
    q <= {q[LastIdx-1:0], d_i};
  end

  assign first_o = q[0];
  assign last_o  = q[LastIdx];
endmodule

// File: rtl/sdly_unit.sv
module sdly_unit #(
  parameter int unsigned STAGES = 64
) (
  input  logic clk_i,
  input  logic sel_i,
  input  logic din_a_i,
  input  logic din_b_i,
  output logic dout_o,
  output logic dout_n_o,
  output logic clk_o,
  output logic first_o
);
  logic in_bit;
  logic last_bit;

  sdly_in_mux u_mux (
    .sel_i (sel_i),
    .a_i   (din_a_i),
    .b_i   (din_b_i),
    .y_o   (in_bit)
  );

  sdly_shift_line #(.STAGES(STAGES)) u_line (
    .clk_i   (clk_i),
    .d_i     (in_bit),
    .first_o (first_o),
    .last_o  (last_bit)
  );

  assign dout_o   = last_bit;
  assign dout_n_o = ~last_bit;
  assign clk_o    = clk_i;
endmodule

// File: rtl/sdly_cascade.sv
module sdly_cascade #(
  parameter int unsigned STAGES  = sdly_pkg::SEG_STAGES,
  parameter int unsigned NUM_DEV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic din_i,
  output logic dout_o,
  output logic dout_n_o,
  output logic clk_o
);
  localparam int unsigned TailIdx = NUM_DEV - 1;

  logic [TailIdx:0] dev_clk;
  logic [TailIdx:0] dev_clk_out;
  logic [TailIdx:0] first_bits;
  logic [TailIdx:0] last_bits;
  logic [TailIdx:0] dout_n_bits;
  logic             hold_q;

  // system clock enters at the output end and ripples toward the head
  assign dev_clk[TailIdx] = clk_i;

  for (genvar k = 0; k < NUM_DEV; k++) begin : g_dev
    if (k == 0) begin : g_head
      sdly_unit #(.STAGES(STAGES)) u_dev (
        .clk_i    (dev_clk[k]),
        .sel_i    (sel_i),
        .din_a_i  (din_i),
        .din_b_i  (hold_q),
        .dout_o   (last_bits[k]),
        .dout_n_o (dout_n_bits[k]),
        .clk_o    (dev_clk_out[k]),
        .first_o  (first_bits[k])
      );
    end else begin : g_body
      sdly_unit #(.STAGES(STAGES)) u_dev (
        .clk_i    (dev_clk[k]),
        .sel_i    (1'b0),
        .din_a_i  (last_bits[k-1]),
        .din_b_i  (1'b0),
        .dout_o   (last_bits[k]),
        .dout_n_o (dout_n_bits[k]),
        .clk_o    (dev_clk_out[k]),
        .first_o  (first_bits[k])
      );
      assign dev_clk[k-1] = dev_clk_out[k];
    end
  end

  // keeps the tail bit until the head segment has taken it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= last_bits[TailIdx];
  end

  assign dout_o   = last_bits[TailIdx];
  assign dout_n_o = dout_n_bits[TailIdx];
  assign clk_o    = dev_clk_out[0];
endmodule

// File: rtl/sdly_cascade_chk.sv
module sdly_cascade_chk #(
  parameter int unsigned NUM_DEV = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sel_i,
  input logic               din_i,
  input logic               dout_o,
  input logic               dout_n_o,
  input logic               clk_o,
  input logic [NUM_DEV-1:0] first_bits,
  input logic [NUM_DEV-1:0] last_bits,
  input logic [NUM_DEV-1:0] dout_n_bits,
  input logic               hold_q
);
  assert_compl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(dout_o) |-> (dout_n_o == ~dout_o));

  assert_load_din_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && !$isunknown(din_i)) |=> (first_bits[0] == $past(din_i)));

  assert_load_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !$isunknown(hold_q)) |=> (first_bits[0] == $past(hold_q)));

  assert_hold_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(last_bits[NUM_DEV-1]) |=> (hold_q == $past(last_bits[NUM_DEV-1])));

  assert_clk_pass_R5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    clk_o);

  for (genvar k = 0; k < NUM_DEV; k++) begin : g_seg
    assert_seg_compl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$isunknown(last_bits[k]) |-> (dout_n_bits[k] == ~last_bits[k]));
    if (k > 0) begin : g_link
      assert_seg_link_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$isunknown(last_bits[k-1]) |=> (first_bits[k] == $past(last_bits[k-1])));
    end
  end
endmodule

bind sdly_cascade sdly_cascade_chk #(.NUM_DEV(NUM_DEV)) i_sdly_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sel_i       (sel_i),
  .din_i       (din_i),
  .dout_o      (dout_o),
  .dout_n_o    (dout_n_o),
  .clk_o       (clk_o),
  .first_bits  (first_bits),
  .last_bits   (last_bits),
  .dout_n_bits (dout_n_bits),
  .hold_q      (hold_q)
);

// File: tb/test_sdly_cascade.sv
`timescale 1ns/1ps
module test_sdly_cascade;
  localparam int unsigned STAGES  = 64;
  localparam int unsigned NUM_DEV = 2;
  localparam int unsigned DEPTH   = STAGES * NUM_DEV;
  localparam int unsigned PERIOD  = DEPTH + 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sel_i = 1'b0;
  logic din_i = 1'b0;
  logic dout_o, dout_n_o, clk_o;

  int n_checks = 0;
  int n_fails  = 0;
  logic mq[$];
  logic hold_m = 1'b0;
  logic out_hist[$];

  always #10 clk = ~clk;

  sdly_cascade #(.STAGES(STAGES), .NUM_DEV(NUM_DEV)) i_sdly_cascade (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .sel_i    (sel_i),
    .din_i    (din_i),
    .dout_o   (dout_o),
    .dout_n_o (dout_n_o),
    .clk_o    (clk_o)
  );

  task automatic check(input bit ok, input string req, input logic act, input logic exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // one rising edge; inputs driven during the low phase
  task automatic step(input logic s, input logic d, input string tag);
    logic nb, old_last, exp, pre;
    sel_i = s;
    din_i = d;
    @(posedge clk);
    nb = s ? hold_m : d;
    old_last = mq[$];
    void'(mq.pop_back());
    mq.push_front(nb);
    hold_m = rst_ni ? old_last : 1'b0;
    exp = mq[$];
    #2;
    check(clk_o === 1'b1, "R5", clk_o, 1'b1);
    pre = dout_o;
    din_i = ~d;
    sel_i = ~s;
    #3;
    din_i = d;
    #2;
    din_i = ~d;
    @(negedge clk);
    #1;
    check(clk_o === 1'b0, "R5", clk_o, 1'b0);
    if (!$isunknown(pre)) check(dout_o === pre, "R6", dout_o, pre);
    if (!$isunknown(dout_o)) check(dout_n_o === ~dout_o, "R1", dout_n_o, ~dout_o);
    if (!$isunknown(exp)) check(dout_o === exp, tag, dout_o, exp);
    out_hist.push_back(dout_o);
  endtask

  initial begin : watchdog
    #(200000 * 20);
    n_fails++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    int cnt;
    for (int i = 0; i < DEPTH; i++) mq.push_back(1'bx);
    #5;
    check(clk_o === 1'b0, "R5", clk_o, 1'b0);
    #10;
    check(clk_o === 1'b1, "R5", clk_o, 1'b1);
    #10;
    rst_ni = 1'b1;
    hold_m = 1'b0;

    // flush with known data through input A
    for (int i = 0; i < DEPTH + 20; i++) step(1'b0, 1'($urandom_range(0, 1)), "R2");

    // single one travelling through zeros: latency in edges
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b0, "R2");
    step(1'b0, 1'b1, "R2");
    cnt = 1;
    while (dout_o !== 1'b1 && cnt < 3 * DEPTH) begin
      step(1'b0, 1'b0, "R2");
      cnt++;
    end
    check(cnt == DEPTH, "R2", 1'(cnt == DEPTH), 1'b1);

    // recirculation with noise on din_i
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'($urandom_range(0, 1)), "R2");
    out_hist.delete();
    for (int i = 0; i < 3 * PERIOD; i++) step(1'b1, 1'($urandom_range(0, 1)), "R3");
    for (int t = PERIOD + 2; t < out_hist.size(); t++)
      if (t % 37 == 0)
        check(out_hist[t] === out_hist[t-PERIOD], "R3", out_hist[t], out_hist[t-PERIOD]);

    // select toggling every edge
    for (int i = 0; i < 2 * DEPTH; i++) step(1'(i % 2), 1'($urandom_range(0, 1)), "R4");
    for (int i = 0; i < DEPTH; i++) step(1'(i % 3 == 0), 1'($urandom_range(0, 1)), "R4");

    // reset pulse between edges: stages kept, hold cleared
    #3;
    rst_ni = 1'b0;
    #3;
    rst_ni = 1'b1;
    hold_m = 1'b0;
    step(1'b1, 1'b1, "R7");
    for (int i = 0; i < DEPTH + 10; i++) step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R7");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule